// File: doc/BRIEF.md
# Dual Data Pointer Register File

This block keeps two 16-bit memory pointers and one pointer-select bit in a byte-wide special-function register space. A processor core reads and writes any byte of either pointer, or the select register, through a simple strobe bus. The core can also increment the active pointer or load it with a full 16-bit value in one cycle. The block drives the pointer that the select bit names onto the data-address path at all times.

A block-copy loop loads the source address into one pointer and the destination address into the other. It then moves between them by incrementing the select register, which is a one-cycle flip. Software that never writes the select register sees only pointer 0, which then acts as a plain single data pointer. Byte writes on the register bus reach either pointer whatever the select bit holds. Pointer increment and pointer load act only on the selected pointer.

Top module: `dual_dptr_file`

## Requirements
- R1: After reset both pointers and the select bit are zero, so `active_ptr` reads 0x0000 and every mapped register reads 0x00.
- R2: Pointer 0 sits at register addresses 0x82 (bits 7:0) and 0x83 (bits 15:8). Pointer 1 sits at 0x84 (bits 7:0) and 0x85 (bits 15:8). A byte written at one of these addresses reads back unchanged at the same address.
- R3: The select register at 0x86 stores only bit 0 of a write. Bits 7:1 of a read from 0x86 are always zero.
- R4: `active_ptr` equals pointer 0 when the select bit is 0 and pointer 1 when it is 1. It holds its value in any cycle with no write, increment or load.
- R5: `ptr_inc` adds one to the selected pointer at the next clock edge and wraps 0xFFFF to 0x0000. The other pointer is unchanged.
- R6: `ptr_load` copies `load_val` into the selected pointer at the next clock edge and leaves the other pointer unchanged. When `ptr_load` and `ptr_inc` are both high, the load wins.
- R7: `sfr_inc` adds one to the addressed register. At 0x86 this flips the select bit. At a pointer byte it adds one to that byte alone, with 8-bit wrap and no carry into the other byte. If `sfr_wr` is also high, the write wins.
- R8: A byte write to a pointer address updates that pointer whichever pointer is selected.
- R9: If a register write or increment hits a byte of the selected pointer in the same cycle as `ptr_inc` or `ptr_load`, the addressed byte takes the register-bus result. The other byte takes the result of the pointer operation.
- R10: `ptr_inc` and `ptr_load` act on the pointer selected before the clock edge, even when the select register changes at that same edge.
- R11: `sfr_rdata` is 0x00 while `sfr_rd` is low and when the address maps to no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sfr_addr | input | 8 | Register-bus byte address |
| sfr_wdata | input | 8 | Register-bus write data |
| sfr_wr | input | 1 | Byte write strobe |
| sfr_inc | input | 1 | Byte increment strobe for the addressed register |
| sfr_rd | input | 1 | Read strobe |
| ptr_inc | input | 1 | Increment the selected pointer |
| ptr_load | input | 1 | Load the selected pointer from load_val |
| load_val | input | 16 | Value for ptr_load |
| sfr_rdata | output | 8 | Read data, combinational |
| active_ptr | output | 16 | Selected pointer, to the data-address path |

## Verification
Register-bus traffic and pointer operations can land in the same cycle, and this is where the design is most likely to go wrong. The directed tests drive a byte write to the selected pointer together with `ptr_inc` across a low-byte carry, and a byte write together with `ptr_load`. Each merged value is compared byte by byte against the rule in R9. A select write and a select increment are also paired with pointer operations. Reading back both pointers then shows that the operation struck the pointer selected before the edge.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
   typedef logic [7:0] sfr_byte_t;

   function automatic sfr_byte_t slot_byte_addr(input int base, input int slot,
                                                input int nbytes, input int b);
      return sfr_byte_t'(base + slot * nbytes + b);
   endfunction
endpackage

// File: rtl/dptr_slot.sv
module dptr_slot #(
   parameter int PTR_W = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   sel_me,
   input  logic                   op_inc,
   input  logic                   op_load,
   input  logic [PTR_W-1:0]       load_val,
   input  logic [PTR_W/8-1:0]     byte_wr,
   input  logic [PTR_W/8-1:0]     byte_inc,
   input  logic [7:0]             wdata,
   output logic [PTR_W-1:0]       q
);
   localparam int NB = PTR_W / 8;

   logic [PTR_W-1:0] whole_nxt;
   logic [7:0]       byte_nxt [NB];

   always_comb begin
      whole_nxt = q;
      if (sel_me && op_load)      whole_nxt = load_val;
      else if (sel_me && op_inc)  whole_nxt = q + PTR_W'(1);
   end

   for (genvar b = 0; b < NB; b++) begin : g_byte
      always_comb begin
         if (byte_wr[b])       byte_nxt[b] = wdata;
         else if (byte_inc[b]) byte_nxt[b] = q[b*8 +: 8] + 8'd1;
         else                  byte_nxt[b] = whole_nxt[b*8 +: 8];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q[b*8 +: 8] <= '0;
         else        q[b*8 +: 8] <= byte_nxt[b];
      end
   end
endmodule

// File: rtl/dptr_sel.sv
module dptr_sel #(
   parameter int SEL_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             inc,
   input  logic [SEL_W-1:0] wdata,
   output logic [SEL_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (wr)  q <= wdata;
      else if (inc) q <= q + SEL_W'(1);
   end
endmodule

// File: rtl/dual_dptr_file.sv
module dual_dptr_file #(
   parameter int PTR_W     = 16,
   parameter int N_PTR     = 2,
   parameter int BASE_ADDR = 'h82
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       sfr_addr,
   input  logic [7:0]       sfr_wdata,
   input  logic             sfr_wr,
   input  logic             sfr_inc,
   input  logic             sfr_rd,
   input  logic             ptr_inc,
   input  logic             ptr_load,
   input  logic [PTR_W-1:0] load_val,
   output logic [7:0]       sfr_rdata,
   output logic [PTR_W-1:0] active_ptr
);
   import dptr_pkg::*;

   localparam int NB       = PTR_W / 8;
   localparam int SEL_W    = $clog2(N_PTR);
   localparam int SEL_ADDR = BASE_ADDR + N_PTR * NB;

   if (PTR_W % 8 != 0 || PTR_W < 8)
      $error("PTR_W must be a nonzero multiple of 8");
   if (N_PTR < 2 || (N_PTR & (N_PTR - 1)) != 0)
      $error("N_PTR must be a power of two, at least 2");
   if (SEL_ADDR > 255)
      $error("register map exceeds the 8-bit address space");

   logic [SEL_W-1:0] sel_q;
   logic [PTR_W-1:0] ptrs [N_PTR];
   logic             sel_hit;

   assign sel_hit = (sfr_addr == sfr_byte_t'(SEL_ADDR));

   dptr_sel #(.SEL_W(SEL_W)) u_sel (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (sfr_wr && sel_hit),
      .inc   (sfr_inc && !sfr_wr && sel_hit),
      .wdata (sfr_wdata[SEL_W-1:0]),
      .q     (sel_q)
   );

   for (genvar k = 0; k < N_PTR; k++) begin : g_slot
      logic [NB-1:0] hit;
      for (genvar b = 0; b < NB; b++) begin : g_dec
         assign hit[b] = (sfr_addr == slot_byte_addr(BASE_ADDR, k, NB, b));
      end
      dptr_slot #(.PTR_W(PTR_W)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .sel_me   (sel_q == SEL_W'(k)),
         .op_inc   (ptr_inc),
         .op_load  (ptr_load),
         .load_val (load_val),
         .byte_wr  (hit & {NB{sfr_wr}}),
         .byte_inc (hit & {NB{sfr_inc && !sfr_wr}}),
         .wdata    (sfr_wdata),
         .q        (ptrs[k])
      );
   end

   assign active_ptr = ptrs[sel_q];

   always_comb begin
      sfr_rdata = '0;
      if (sfr_rd) begin
         if (sel_hit) sfr_rdata = sfr_byte_t'(sel_q);
         for (int k = 0; k < N_PTR; k++)
            for (int b = 0; b < NB; b++)
               if (sfr_addr == slot_byte_addr(BASE_ADDR, k, NB, b))
                  sfr_rdata = ptrs[k][b*8 +: 8];
      end
   end
endmodule

// File: rtl/dptr_file_chk.sv
module dptr_file_chk #(
   parameter int PTR_W    = 16,
   parameter int SEL_W    = 1,
   parameter int SEL_ADDR = 'h86
) (
   input logic             clk,
   input logic             rst_n,
   input logic [7:0]       sfr_addr,
   input logic             sfr_wr,
   input logic             sfr_inc,
   input logic             sfr_rd,
   input logic             ptr_inc,
   input logic             ptr_load,
   input logic [PTR_W-1:0] load_val,
   input logic [7:0]       sfr_rdata,
   input logic [PTR_W-1:0] active_ptr,
   input logic [SEL_W-1:0] sel_q
);
   logic quiet_bus;
   assign quiet_bus = !sfr_wr && !sfr_inc;

   p_idle_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !sfr_rd |-> sfr_rdata == 8'h00);

   p_sel_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sfr_rd && sfr_addr == 8'(SEL_ADDR)) |-> sfr_rdata[7:SEL_W] == '0);

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet_bus && !ptr_inc && !ptr_load) |=> $stable(active_ptr));

   p_inc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet_bus && ptr_inc && !ptr_load) |=> active_ptr == $past(active_ptr) + PTR_W'(1));

   p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet_bus && ptr_load) |=> active_ptr == $past(load_val));

   p_sel_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sfr_inc && !sfr_wr && sfr_addr == 8'(SEL_ADDR)) |=> sel_q == $past(sel_q) + SEL_W'(1));
endmodule

bind dual_dptr_file dptr_file_chk #(
   .PTR_W(PTR_W), .SEL_W(SEL_W), .SEL_ADDR(SEL_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
   .sfr_inc(sfr_inc), .sfr_rd(sfr_rd), .ptr_inc(ptr_inc), .ptr_load(ptr_load),
   .load_val(load_val), .sfr_rdata(sfr_rdata), .active_ptr(active_ptr),
   .sel_q(sel_q)
);

// File: tb/sim_dual_dptr_file.sv
module sim_dual_dptr_file;
   timeunit 1ns;
   timeprecision 1ps;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  sfr_addr = '0;
   logic [7:0]  sfr_wdata = '0;
   logic        sfr_wr = 1'b0;
   logic        sfr_inc = 1'b0;
   logic        sfr_rd = 1'b0;
   logic        ptr_inc = 1'b0;
   logic        ptr_load = 1'b0;
   logic [15:0] load_val = '0;
   logic [7:0]  sfr_rdata;
   logic [15:0] active_ptr;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   dual_dptr_file u0 (
      .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
      .sfr_wr(sfr_wr), .sfr_inc(sfr_inc), .sfr_rd(sfr_rd), .ptr_inc(ptr_inc),
      .ptr_load(ptr_load), .load_val(load_val), .sfr_rdata(sfr_rdata),
      .active_ptr(active_ptr)
   );

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic op(input logic wr, input logic sinc, input logic [7:0] a,
                     input logic [7:0] d, input logic pinc, input logic pload,
                     input logic [15:0] lv);
      @(negedge clk);
      sfr_wr = wr; sfr_inc = sinc; sfr_addr = a; sfr_wdata = d;
      ptr_inc = pinc; ptr_load = pload; load_val = lv;
      @(posedge clk);
      #1;
      sfr_wr = 0; sfr_inc = 0; ptr_inc = 0; ptr_load = 0;
   endtask

   task automatic wr8(input logic [7:0] a, input logic [7:0] d);
      op(1, 0, a, d, 0, 0, '0);
   endtask

   task automatic rd8(input logic [7:0] a, output logic [7:0] v);
      sfr_addr = a; sfr_rd = 1;
      #2 v = sfr_rdata;
      sfr_rd = 0;
   endtask

   task automatic chk_reg(input string tag, input logic [7:0] a, input logic [7:0] exp);
      logic [7:0] v;
      rd8(a, v);
      chk(tag, {8'h00, v}, {8'h00, exp});
   endtask

   task automatic t_reset;
      chk("R1 active after reset", active_ptr, 16'h0000);
      for (int a = 'h82; a <= 'h86; a++) chk_reg("R1 reg after reset", 8'(a), 8'h00);
   endtask

   task automatic t_map;
      wr8(8'h82, 8'h34); wr8(8'h83, 8'h12);
      wr8(8'h84, 8'hCD); wr8(8'h85, 8'hAB);
      chk_reg("R2 p0 low", 8'h82, 8'h34);
      chk_reg("R2 p0 high", 8'h83, 8'h12);
      chk_reg("R8 p1 low written while p0 selected", 8'h84, 8'hCD);
      chk_reg("R8 p1 high written while p0 selected", 8'h85, 8'hAB);
      chk("R4 active is p0", active_ptr, 16'h1234);
      chk_reg("R11 unmapped 0x87", 8'h87, 8'h00);
      chk_reg("R11 unmapped 0x81", 8'h81, 8'h00);
      sfr_addr = 8'h83; #2;
      chk("R11 no read strobe", {8'h00, sfr_rdata}, 16'h0000);
   endtask

   task automatic t_select;
      wr8(8'h86, 8'hFF);
      chk_reg("R3 select keeps only bit 0", 8'h86, 8'h01);
      chk("R4 active is p1", active_ptr, 16'hABCD);
      wr8(8'h82, 8'h35);
      chk_reg("R8 p0 written while p1 selected", 8'h82, 8'h35);
      chk("R4 active unaffected by p0 write", active_ptr, 16'hABCD);
      wr8(8'h86, 8'hFE);
      chk_reg("R3 select bit cleared", 8'h86, 8'h00);
      chk("R4 active back to p0", active_ptr, 16'h1235);
   endtask

   task automatic t_inc;
      wr8(8'h82, 8'hFE); wr8(8'h83, 8'hFF);
      op(0, 0, 8'h00, 8'h00, 1, 0, '0);
      chk("R5 increment", active_ptr, 16'hFFFF);
      op(0, 0, 8'h00, 8'h00, 1, 0, '0);
      chk("R5 wrap to zero", active_ptr, 16'h0000);
      chk_reg("R5 p1 low untouched", 8'h84, 8'hCD);
      chk_reg("R5 p1 high untouched", 8'h85, 8'hAB);
   endtask

   task automatic t_load;
      wr8(8'h86, 8'h01);
      op(0, 0, 8'h00, 8'h00, 0, 1, 16'h5A5A);
      chk("R6 load into p1", active_ptr, 16'h5A5A);
      chk_reg("R6 p0 untouched", 8'h83, 8'h00);
      op(0, 0, 8'h00, 8'h00, 1, 1, 16'h7001);
      chk("R6 load beats increment", active_ptr, 16'h7001);
   endtask

   task automatic t_sfr_inc;
      op(0, 1, 8'h86, 8'h00, 0, 0, '0);
      chk_reg("R7 select flipped to 0", 8'h86, 8'h00);
      chk("R7 active follows flip", active_ptr, 16'h0000);
      op(0, 1, 8'h86, 8'h00, 0, 0, '0);
      chk_reg("R7 select flipped to 1", 8'h86, 8'h01);
      wr8(8'h82, 8'hFF); wr8(8'h83, 8'h10);
      op(0, 1, 8'h82, 8'h00, 0, 0, '0);
      chk_reg("R7 byte wraps", 8'h82, 8'h00);
      chk_reg("R7 no carry", 8'h83, 8'h10);
      op(1, 1, 8'h86, 8'h01, 0, 0, '0);
      chk_reg("R7 write beats increment", 8'h86, 8'h01);
   endtask

   task automatic t_collide;
      wr8(8'h86, 8'h00);
      wr8(8'h82, 8'hFF); wr8(8'h83, 8'h12);
      op(1, 0, 8'h83, 8'h55, 1, 0, '0);
      chk("R9 write high with increment", active_ptr, 16'h5500);
      op(1, 0, 8'h82, 8'h11, 0, 1, 16'hBEEF);
      chk("R9 write low with load", active_ptr, 16'hBE11);
   endtask

   task automatic t_sel_race;
      wr8(8'h84, 8'h00); wr8(8'h85, 8'h20);
      op(1, 0, 8'h86, 8'h01, 1, 0, '0);
      chk("R10 active now p1 unchanged", active_ptr, 16'h2000);
      chk_reg("R10 p0 incremented low", 8'h82, 8'h12);
      op(0, 1, 8'h86, 8'h00, 0, 1, 16'hC0DE);
      chk("R10 active now p0", active_ptr, 16'hBE12);
      chk_reg("R10 p1 loaded low", 8'h84, 8'hDE);
      chk_reg("R10 p1 loaded high", 8'h85, 8'hC0);
   endtask

   initial begin
      #35;
      t_reset;
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #1;
      t_reset;
      t_map;
      t_select;
      t_inc;
      t_load;
      t_sfr_inc;
      t_collide;
      t_sel_race;
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=complete");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule